// File: doc/BRIEF.md
# Match-and-Capture Timer

A 32-bit up-counter advances once each time a programmable prescaler wraps. Four compare registers watch the count. Each compare slot has three independent actions that take effect when it hits: raise a flag, clear the count, or halt counting. Each compare slot that has an external pin also applies a pin action when it hits: keep, drive low, drive high, or invert. A set of capture channels records the count when a synchronised input shows a chosen edge. Each capture can also raise a flag. The number of pins and captures is a parameter, either 3 or 4.

Software reaches the block through a plain single-cycle register port, addressed by 32-bit word. A write takes effect at the clock edge on which `bus_we` is high. A read is combinational from `bus_addr`. The block never stalls, so this port has no valid/ready pair and no back-pressure: every write is accepted on the cycle it is presented. Pins, captures and the interrupt line are plain level signals.

The address map is:

| Address | Name | Contents |
|---|---|---|
| 0x0 | control | bit 0 = run, bit 1 = hold |
| 0x1 | prescale limit | |
| 0x2 | prescale count | read only |
| 0x3 | timer count | read only |
| 0x4 | flags | bits 3:0 = compare slots, bits 4+j = capture j; write 1 to clear |
| 0x5 | compare actions | 3 bits per slot i at [3i+2:3i] = {halt, clear, flag} |
| 0x6 | pin actions | 2 bits per pin j at [2j+1:2j]: 00 keep, 01 low, 10 high, 11 invert |
| 0x7 | capture select | 3 bits per channel j at [3j+2:3j] = {flag, falling, rising} |
| 0x8-0xB | compare values, slots 0-3 | |
| 0xC-0xF | captured values, channels 0-3 | read only; absent channels read 0 |

Top module: `mc_timer`

## Requirements
- R1: After reset every register, both counts, every pin output and `irq` are 0.
- R2: With run set (control bit 0) and a prescale limit P, the prescale count steps 0..P. Each time it wraps from P to 0 the timer count advances by one, so the timer advances once every P+1 cycles.
- R3: While hold (control bit 1) is set, the prescale count and the timer count stay at 0, even if run is also set.
- R4: A compare slot hits on a timer advance taken while the timer count equals its compare value. If that slot's flag action (bit 3i) is set, flag bit i is set and `irq` goes high. If the flag action is clear, the slot leaves its flag bit alone.
- R5: If the clear action (bit 3i+1) of a hitting slot is set, the timer count becomes 0 at that advance instead of the compare value plus one.
- R6: If the halt action (bit 3i+2) of a hitting slot is set, run is cleared and the timer count stays at the compare value.
- R7: On each hit of slot j, pin j follows its pin action code: 00 keep, 01 low, 10 high, 11 invert.
- R8: Capture input j passes through a two-flop synchroniser. An edge enabled in its select field (bit 3j = rising, bit 3j+1 = falling) loads the current timer count into captured value j. If the flag bit (3j+2) is set, it also sets flag bit 4+j. An edge that is not enabled changes nothing.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly when some flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| cap_in | input | NCH | Capture inputs, asynchronous |
| match_out | output | NCH | Compare-driven pins |
| irq | output | 1 | OR of all flag bits |

## Verification
A register write becomes visible one edge after it is presented. A compare hit changes the counts, the flags, run and the pins at the same edge as the advance it rides on. A capture loads on the third edge after its input changes: two synchroniser edges and one load edge. The bench freezes the timer by clearing run before it reads a count, so every expected count is an edge tally from the write that started counting. It reads results at a falling edge at least one full cycle after the last edge that could move them, and captures are read four cycles after the input changes.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;
  localparam int NSLOT = 4;

  localparam logic [3:0] A_CTRL  = 4'h0;
  localparam logic [3:0] A_PLIM  = 4'h1;
  localparam logic [3:0] A_PCNT  = 4'h2;
  localparam logic [3:0] A_TCNT  = 4'h3;
  localparam logic [3:0] A_FLAGS = 4'h4;
  localparam logic [3:0] A_MCFG  = 4'h5;
  localparam logic [3:0] A_OCFG  = 4'h6;
  localparam logic [3:0] A_CCFG  = 4'h7;

  typedef enum logic [1:0] {
    OUT_KEEP = 2'b00,
    OUT_LOW  = 2'b01,
    OUT_HIGH = 2'b10,
    OUT_FLIP = 2'b11
  } out_act_e;

  typedef struct packed {
    logic stop;
    logic clr;
    logic irq;
  } match_act_t;

  typedef struct packed {
    logic irq;
    logic fall;
    logic rise;
  } cap_sel_t;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  logic [DW-1:0] plimit,
  input  logic          clr_hit,
  input  logic          stop_hit,
  output logic [DW-1:0] pc,
  output logic [DW-1:0] tc,
  output logic          tick
);
  localparam logic [DW-1:0] ONE = DW'(1);

  assign tick = run && !hold && (pc == plimit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      tc <= '0;
    end else if (hold) begin
      pc <= '0;
      tc <= '0;
    end else if (tick) begin
      pc <= '0;
      if (clr_hit)
        tc <= '0;
      else if (!stop_hit)
        tc <= tc + ONE;
    end else if (run) begin
      pc <= pc + ONE;
    end
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import mc_timer_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NCH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic [DW-1:0]               tc,
  input  logic [NSLOT-1:0][DW-1:0]    mr,
  input  match_act_t [NSLOT-1:0]      acts,
  input  logic [NCH-1:0][1:0]         oact,
  output logic [NSLOT-1:0]            hit,
  output logic [NSLOT-1:0]            irq_set,
  output logic                        clr_hit,
  output logic                        stop_hit,
  output logic [NCH-1:0]              pins
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign hit[i] = tick && (tc == mr[i]);
  end

  always_comb begin
    clr_hit  = 1'b0;
    stop_hit = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      irq_set[i] = hit[i] & acts[i].irq;
      clr_hit    = clr_hit  | (hit[i] & acts[i].clr);
      stop_hit   = stop_hit | (hit[i] & acts[i].stop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= '0;
    end else begin
      for (int j = 0; j < NCH; j++) begin
        if (hit[j]) begin
          case (out_act_e'(oact[j]))
            OUT_LOW:  pins[j] <= 1'b0;
            OUT_HIGH: pins[j] <= 1'b1;
            OUT_FLIP: pins[j] <= ~pins[j];
            default:  pins[j] <= pins[j];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          en_rise,
  input  logic          en_fall,
  input  logic [DW-1:0] tc,
  output logic [DW-1:0] snap,
  output logic          fire
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin};
  end

  assign fire = (en_rise & sh[1] & ~sh[2]) | (en_fall & ~sh[1] & sh[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap <= '0;
    else if (fire) snap <= tc;
  end
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mc_timer_pkg::*;
#(
  parameter int DW  = 32,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [3:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] cap_in,
  output logic [NCH-1:0] match_out,
  output logic           irq
);
  localparam int FW = NSLOT + NCH;
  localparam int MW = 3 * NSLOT;
  localparam int OW = 2 * NCH;
  localparam int CW = 3 * NCH;

  logic                     run_q, hold_q;
  logic [DW-1:0]            plimit_q;
  logic [NSLOT-1:0][DW-1:0] mr_q;
  match_act_t [NSLOT-1:0]   mcfg_q;
  logic [NCH-1:0][1:0]      ocfg_q;
  cap_sel_t [NCH-1:0]       ccfg_q;
  logic [FW-1:0]            flags_q;

  logic [DW-1:0]            pc_w, tc_w;
  logic                     tick, clr_hit, stop_hit;
  logic [NSLOT-1:0]         hit_w, m_irq;
  logic [NCH-1:0]           cap_fire, c_irq;
  logic [NSLOT-1:0][DW-1:0] cap_pad;

  wire wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  wire wr_plim  = bus_we && (bus_addr == A_PLIM);
  wire wr_flags = bus_we && (bus_addr == A_FLAGS);
  wire wr_mcfg  = bus_we && (bus_addr == A_MCFG);
  wire wr_ocfg  = bus_we && (bus_addr == A_OCFG);
  wire wr_ccfg  = bus_we && (bus_addr == A_CCFG);
  wire wr_mr    = bus_we && (bus_addr[3:2] == 2'b10);

  // control: a halting compare hit overrides a same-cycle write of run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[0];
        hold_q <= bus_wdata[1];
      end
      if (stop_hit) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plimit_q <= '0;
      mr_q     <= '0;
      mcfg_q   <= '0;
      ocfg_q   <= '0;
      ccfg_q   <= '0;
    end else begin
      if (wr_plim) plimit_q <= bus_wdata;
      if (wr_mr)   mr_q[bus_addr[1:0]] <= bus_wdata;
      if (wr_mcfg) mcfg_q <= bus_wdata[MW-1:0];
      if (wr_ocfg) ocfg_q <= bus_wdata[OW-1:0];
      if (wr_ccfg) ccfg_q <= bus_wdata[CW-1:0];
    end
  end

  // flags: new events win over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= '0;
    else
      flags_q <= (flags_q & ~(wr_flags ? bus_wdata[FW-1:0] : {FW{1'b0}}))
               | {c_irq, m_irq};
  end

  assign irq = |flags_q;

  tmr_count #(.DW(DW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .hold    (hold_q),
    .plimit  (plimit_q),
    .clr_hit (clr_hit),
    .stop_hit(stop_hit),
    .pc      (pc_w),
    .tc      (tc_w),
    .tick    (tick)
  );

  tmr_match #(.DW(DW), .NCH(NCH)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .tc      (tc_w),
    .mr      (mr_q),
    .acts    (mcfg_q),
    .oact    (ocfg_q),
    .hit     (hit_w),
    .irq_set (m_irq),
    .clr_hit (clr_hit),
    .stop_hit(stop_hit),
    .pins    (match_out)
  );

  for (genvar j = 0; j < NSLOT; j++) begin : g_cap
    if (j < NCH) begin : g_on
      logic [DW-1:0] snap;
      tmr_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (cap_in[j]),
        .en_rise(ccfg_q[j].rise),
        .en_fall(ccfg_q[j].fall),
        .tc     (tc_w),
        .snap   (snap),
        .fire   (cap_fire[j])
      );
      assign c_irq[j]   = cap_fire[j] & ccfg_q[j].irq;
      assign cap_pad[j] = snap;
    end else begin : g_off
      assign cap_pad[j] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1:0]    = {hold_q, run_q};
      A_PLIM:  bus_rdata         = plimit_q;
      A_PCNT:  bus_rdata         = pc_w;
      A_TCNT:  bus_rdata         = tc_w;
      A_FLAGS: bus_rdata[FW-1:0] = flags_q;
      A_MCFG:  bus_rdata[MW-1:0] = mcfg_q;
      A_OCFG:  bus_rdata[OW-1:0] = ocfg_q;
      A_CCFG:  bus_rdata[CW-1:0] = ccfg_q;
      default: begin
        if (bus_addr[3:2] == 2'b10) bus_rdata = mr_q[bus_addr[1:0]];
        else                        bus_rdata = cap_pad[bus_addr[1:0]];
      end
    endcase
  end
endmodule

// File: rtl/mc_timer_chk.sv
module mc_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_q,
  input logic          run_q,
  input logic          tick,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] tc,
  input logic [3:0]    hits,
  input logic [11:0]   mcfg,
  input logic          irq
);
  logic [3:0] en_irq, en_clr, en_stop;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      en_irq[i]  = mcfg[3*i];
      en_clr[i]  = mcfg[3*i+1];
      en_stop[i] = mcfg[3*i+2];
    end
  end

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (tc == '0 && pc == '0));

  // R2
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pc == '0));

  // R2
  presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hold_q && !tick) |=> (pc == $past(pc) + DW'(1)));

  // R4
  match_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hits & en_irq) != 4'b0) |=> irq);

  // R5
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hits & en_clr) != 4'b0) |=> (tc == '0));

  // R6
  match_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hits & en_stop) != 4'b0) |=> !run_q);
endmodule

bind mc_timer mc_timer_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .hold_q(hold_q),
  .run_q (run_q),
  .tick  (tick),
  .pc    (pc_w),
  .tc    (tc_w),
  .hits  (hit_w),
  .mcfg  (mcfg_q),
  .irq   (irq)
);

// File: tb/mc_timer_test.sv
`timescale 1ns/1ps
module mc_timer_test;
  localparam logic [3:0] RA_CTRL = 4'h0, RA_PLIM = 4'h1, RA_PCNT = 4'h2,
                         RA_TCNT = 4'h3, RA_FLAGS = 4'h4, RA_MCFG = 4'h5,
                         RA_OCFG = 4'h6, RA_CCFG = 4'h7, RA_MR0 = 4'h8,
                         RA_MR1 = 4'h9, RA_CAP0 = 4'hC, RA_CAP1 = 4'hD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  match_out;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  mc_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .match_out(match_out), .irq(irq)
  );

  // monitor: pops every expectation queued at this falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      case (it.kind)
        0:       got = bus_rdata;
        1:       got = {28'b0, match_out};
        default: got = {31'b0, irq};
      endcase
      n_vec++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    sb.push_back('{0, e, tag});
  endtask

  task automatic exp_pins(input logic [3:0] e, input string tag);
    @(negedge clk);
    sb.push_back('{1, {28'b0, e}, tag});
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(negedge clk);
    sb.push_back('{2, {31'b0, e}, tag});
  endtask

  // zero the counts, then let exactly `total` counting edges pass and freeze
  task automatic run_for(input int total);
    wr(RA_CTRL, 32'h2);
    wr(RA_CTRL, 32'h1);
    idle(total - 2);
    wr(RA_CTRL, 32'h0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    exp_reg(RA_CTRL, 32'h0, "R1 control");
    exp_reg(RA_TCNT, 32'h0, "R1 timer count");
    exp_reg(RA_PCNT, 32'h0, "R1 prescale count");
    exp_reg(RA_FLAGS, 32'h0, "R1 flags");
    exp_pins(4'h0, "R1 pins");
    exp_irq(1'b0, "R1 irq");

    // R2 prescale limit 3, ten counting edges -> timer 2, prescale 2
    wr(RA_PLIM, 32'd3);
    run_for(10);
    exp_reg(RA_TCNT, 32'd2, "R2 timer count");
    exp_reg(RA_PCNT, 32'd2, "R2 prescale count");
    exp_reg(RA_CTRL, 32'h0, "R2 control after stop write");

    // R3 hold forces zero, even with run set
    wr(RA_CTRL, 32'h2);
    exp_reg(RA_TCNT, 32'd0, "R3 timer held");
    wr(RA_CTRL, 32'h3);
    idle(5);
    exp_reg(RA_TCNT, 32'd0, "R3 timer held while run");
    exp_reg(RA_PCNT, 32'd0, "R3 prescale held while run");
    wr(RA_CTRL, 32'h0);

    // R4 R5 R7: slot 0 value 4, flag+clear, pin 0 invert
    wr(RA_PLIM, 32'd0);
    wr(RA_MR0, 32'd4);
    wr(RA_MCFG, 32'h3);
    wr(RA_OCFG, 32'h3);
    run_for(7);
    exp_reg(RA_TCNT, 32'd2, "R5 count wrapped at compare");
    exp_reg(RA_FLAGS, 32'h1, "R4 slot 0 flag");
    exp_irq(1'b1, "R4 irq raised");
    exp_pins(4'h1, "R7 invert");

    // R9 write-one-to-clear
    wr(RA_FLAGS, 32'hE);
    exp_reg(RA_FLAGS, 32'h1, "R9 zero bit leaves flag");
    wr(RA_FLAGS, 32'h1);
    exp_reg(RA_FLAGS, 32'h0, "R9 one bit clears flag");
    exp_irq(1'b0, "R9 irq dropped");

    // R6 R7: slot 0 value 1 no actions pin keep; slot 1 value 3 halt+flag, pin high
    wr(RA_MR0, 32'd1);
    wr(RA_MR1, 32'd3);
    wr(RA_MCFG, 32'h28);
    wr(RA_OCFG, 32'h8);
    wr(RA_CTRL, 32'h2);
    wr(RA_CTRL, 32'h1);
    idle(10);
    exp_reg(RA_CTRL, 32'h0, "R6 run cleared");
    exp_reg(RA_TCNT, 32'd3, "R6 count held at compare");
    exp_reg(RA_FLAGS, 32'h2, "R4 unflagged slot stays clear");
    exp_pins(4'h3, "R7 keep and high");

    // R7: pin 0 low at value 2, pin 1 invert at value 3
    wr(RA_FLAGS, 32'hFF);
    wr(RA_MR0, 32'd2);
    wr(RA_OCFG, 32'hD);
    wr(RA_CTRL, 32'h2);
    wr(RA_CTRL, 32'h1);
    idle(10);
    exp_pins(4'h0, "R7 low and invert");
    exp_reg(RA_TCNT, 32'd3, "R6 second halt");
    exp_reg(RA_FLAGS, 32'h2, "R4 second flag");

    // R8 capture: channel 0 rising+flag, channel 1 falling only
    wr(RA_FLAGS, 32'hFF);
    wr(RA_CCFG, 32'h15);
    @(negedge clk) cap_in[0] = 1'b1;
    idle(4);
    exp_reg(RA_CAP0, 32'd3, "R8 rising capture");
    exp_reg(RA_FLAGS, 32'h10, "R8 capture flag");
    exp_irq(1'b1, "R8 irq from capture");
    @(negedge clk) cap_in[1] = 1'b1;
    idle(4);
    exp_reg(RA_CAP1, 32'd0, "R8 disabled rising edge ignored");
    exp_reg(RA_FLAGS, 32'h10, "R8 no flag from ignored edge");

    wr(RA_MCFG, 32'h0);
    run_for(5);
    exp_reg(RA_TCNT, 32'd5, "R2 count before falling capture");
    @(negedge clk) begin
      cap_in[1] = 1'b0;
      cap_in[0] = 1'b0;
    end
    idle(4);
    exp_reg(RA_CAP1, 32'd5, "R8 falling capture");
    exp_reg(RA_CAP0, 32'd3, "R8 disabled falling edge ignored");
    exp_reg(RA_FLAGS, 32'h10, "R8 unflagged capture");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule